// File: doc/BRIEF.md
# Dual-Port Load/Store Hazard Checker

This block sits at the issue stage in front of a load/store resource that has two identical, interchangeable copies. Each cycle it receives one bundle of decoded operations. Every slot of the bundle carries a 2-bit code that says how many copies of the memory resource that slot needs. The block adds up the demand and decides whether the whole bundle may issue or must stall. Partial issue is never allowed.

Grant and stall are combinational from the bundle on the inputs. When a bundle issues, the block works out which port each memory operation gets. It registers that mapping for the next pipeline stage. Every reservation is made at one stage and lasts exactly one cycle, so no occupancy carries from one bundle to the next.

Top module: `lsu_dual_port_hazard`

## Requirements
- R1: While reset is high, and in the first cycle after it, every per-slot port mask output is zero.
- R2: When `bundle_valid_i` is high and the summed demand of all slots is at most two, `issue_grant_o` is high in the same cycle and `stall_o` is low.
- R3: When `bundle_valid_i` is high and the summed demand exceeds two, `stall_o` is high and `issue_grant_o` is low in the same cycle. The two outputs are never high together.
- R4: When `bundle_valid_i` is low, `issue_grant_o` and `stall_o` are both low, and in the next cycle all port masks are zero.
- R5: Demand code 0 (no memory use: ALU, multiply or predicate operation) adds nothing to the demand and receives no port.
- R6: Demand code 2 (dual-vector load) weighs two. When it issues on its own, its slot's mask is `2'b11` (both ports) in the cycle after the grant.
- R7: A code-2 slot together with any other slot of nonzero code stalls the bundle.
- R8: When two code-1 slots issue together, the lower-numbered slot gets mask `2'b01` (port 0) and the higher one gets `2'b10` (port 1), in the cycle after the grant.
- R9: A single code-1 slot that issues on its own always gets port 0 (mask `2'b01`).
- R10: In the cycle after a stall, all port masks are zero; no slot of a stalled bundle is ever given a port.
- R11: Demand code 3 is reserved and weighs three, so a bundle that holds it always stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bundle_valid_i | input | 1 | A bundle is offered for issue this cycle |
| slot_demand_i | input | 2*NUM_SLOTS | Per-slot demand code; slot k is bits [2k+1:2k] |
| issue_grant_o | output | 1 | The bundle issues this cycle |
| stall_o | output | 1 | The bundle is held because its demand exceeds the two copies |
| slot_port_q_o | output | 2*NUM_SLOTS | Registered per-slot port mask; bit 0 means port 0, bit 1 means port 1 |

## Verification
The bench sweeps every combination of the four demand codes over four slots, once with the valid input high and once with it low. It predicts grant, stall and the port masks from the demand sum and the slot order.

- A dual-vector load paired with a single load has a sum of three. A checker that counted memory operations instead of copies would see only two operations and wrongly grant this bundle.
- When two singles sit in non-adjacent slots, a design that ordered them wrongly would put the higher slot on port 0.
- The reserved code must stall even when it stands alone.
- After a stall, a design that let a partial issue through, or kept the previous mapping, would leave a nonzero mask in the cycle after.

// File: rtl/lsu_hz_pkg.sv
package lsu_hz_pkg;

    localparam int unsigned PORT_COUNT = 2;

    typedef enum logic [1:0] {
        DEM_NONE = 2'd0,
        DEM_ONE  = 2'd1,
        DEM_BOTH = 2'd2,
        DEM_RSVD = 2'd3
    } demand_e;

    typedef logic [PORT_COUNT-1:0] port_mask_t;

    localparam port_mask_t MASK_NONE  = 2'b00;
    localparam port_mask_t MASK_PORT0 = 2'b01;
    localparam port_mask_t MASK_PORT1 = 2'b10;
    localparam port_mask_t MASK_BOTH  = 2'b11;

    function automatic int unsigned demand_weight(input demand_e d);
        case (d)
            DEM_NONE: return 0;
            DEM_ONE:  return 1;
            DEM_BOTH: return 2;
            default:  return 3;
        endcase
    endfunction

endpackage

// File: rtl/lsu_hz_demand_sum.sv
module lsu_hz_demand_sum
    import lsu_hz_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4,
    parameter int unsigned SUM_W     = 4
) (
    input  logic [2*NUM_SLOTS-1:0] demand_i,
    output logic [SUM_W-1:0]       total_o
);

    always_comb begin
        int unsigned acc;
        acc = 0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            acc = acc + demand_weight(demand_e'(demand_i[2*i +: 2]));
        end
        total_o = SUM_W'(acc);
    end

endmodule

// File: rtl/lsu_hz_port_assign.sv
module lsu_hz_port_assign
    import lsu_hz_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic [2*NUM_SLOTS-1:0] demand_i,
    output logic [2*NUM_SLOTS-1:0] masks_o
);

    // Single-copy ops take ports in slot order; a dual op takes both.
    always_comb begin
        int unsigned seen;
        port_mask_t  m;
        seen    = 0;
        masks_o = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            m = MASK_NONE;
            case (demand_e'(demand_i[2*i +: 2]))
                DEM_ONE: begin
                    m    = (seen == 0) ? MASK_PORT0 : MASK_PORT1;
                    seen = seen + 1;
                end
                DEM_BOTH: m = MASK_BOTH;
                default:  m = MASK_NONE;
            endcase
            masks_o[2*i +: 2] = m;
        end
    end

endmodule

// File: rtl/lsu_dual_port_hazard.sv
module lsu_dual_port_hazard
    import lsu_hz_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   bundle_valid_i,
    input  logic [2*NUM_SLOTS-1:0] slot_demand_i,
    output logic                   issue_grant_o,
    output logic                   stall_o,
    output logic [2*NUM_SLOTS-1:0] slot_port_q_o
);

    localparam int unsigned SUM_W = $clog2(3*NUM_SLOTS + 1);
    localparam logic [SUM_W-1:0] CAPACITY = SUM_W'(PORT_COUNT);

    logic [SUM_W-1:0]       total_demand;
    logic [2*NUM_SLOTS-1:0] next_masks;
    logic                   fits;

    lsu_hz_demand_sum #(
        .NUM_SLOTS(NUM_SLOTS),
        .SUM_W    (SUM_W)
    ) u_sum (
        .demand_i(slot_demand_i),
        .total_o (total_demand)
    );

    lsu_hz_port_assign #(
        .NUM_SLOTS(NUM_SLOTS)
    ) u_assign (
        .demand_i(slot_demand_i),
        .masks_o (next_masks)
    );

    assign fits          = (total_demand <= CAPACITY);
    assign issue_grant_o = bundle_valid_i & fits;
    assign stall_o       = bundle_valid_i & ~fits;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_reg
        port_mask_t mask_q;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                mask_q <= MASK_NONE;
            end else if (issue_grant_o) begin
                mask_q <= next_masks[2*s +: 2];
            end else begin
                mask_q <= MASK_NONE;
            end
        end
        assign slot_port_q_o[2*s +: 2] = mask_q;
    end

endmodule

// File: rtl/lsu_hz_checker.sv
module lsu_hz_checker #(
    parameter int unsigned NUM_SLOTS = 4
) (
    input logic                   clk_i,
    input logic                   rst_i,
    input logic                   bundle_valid_i,
    input logic                   issue_grant_o,
    input logic                   stall_o,
    input logic [2*NUM_SLOTS-1:0] slot_port_q_o
);

    logic [NUM_SLOTS-1:0] col0;
    logic [NUM_SLOTS-1:0] col1;

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            col0[i] = slot_port_q_o[2*i];
            col1[i] = slot_port_q_o[2*i+1];
        end
    end

    AST_GRANT_STALL_EXCL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(issue_grant_o && stall_o)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !bundle_valid_i |-> (!issue_grant_o && !stall_o)); // R4

    AST_NO_MAP_AFTER_STALL: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_o |=> (slot_port_q_o == '0)); // R10

    AST_PORT0_OWNER_UNIQUE: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(col0)); // R8

    AST_PORT1_OWNER_UNIQUE: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(col1)); // R8

    AST_PORT0_FILLS_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
        (col1 != '0) |-> (col0 != '0)); // R9

endmodule

bind lsu_dual_port_hazard lsu_hz_checker #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .bundle_valid_i(bundle_valid_i),
    .issue_grant_o (issue_grant_o),
    .stall_o       (stall_o),
    .slot_port_q_o (slot_port_q_o)
);

// File: tb/sim_lsu_dual_port_hazard.sv
`timescale 1ns/1ps
module sim_lsu_dual_port_hazard;

    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          vld;
    logic [2*NS-1:0] dem;
    logic          grant;
    logic          stall;
    logic [2*NS-1:0] masks;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    lsu_dual_port_hazard #(.NUM_SLOTS(NS)) u0 (
        .clk_i(clk), .rst_i(rst), .bundle_valid_i(vld),
        .slot_demand_i(dem), .issue_grant_o(grant), .stall_o(stall),
        .slot_port_q_o(masks)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s dem=%b vld=%0b act=%0h exp=%0h", req, dem, vld, act, exp);
        end
    endtask

    function automatic string req_tag(input logic [2*NS-1:0] d, input int sum);
        int n2 = 0, n3 = 0, n1 = 0;
        for (int i = 0; i < NS; i++) begin
            if (d[2*i +: 2] == 2'd3) n3++;
            if (d[2*i +: 2] == 2'd2) n2++;
            if (d[2*i +: 2] == 2'd1) n1++;
        end
        if (n3 > 0) return "R11";
        if (n2 > 0 && sum > 2) return "R7";
        if (n2 > 0) return "R6";
        if (n1 == 2) return "R8";
        if (n1 == 1) return "R9";
        if (sum > 2) return "R3";
        if (sum == 0) return "R5";
        return "R2";
    endfunction

    initial begin
        logic [2*NS-1:0] expm;
        int sum, ones;
        bit  ok;
        string tag;
        rst = 1'b1; vld = 1'b0; dem = '0;
        @(negedge clk);
        check("R1", 32'(masks), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 32'(masks), 0);
        for (int pass = 0; pass < 2; pass++) begin
            for (int code = 0; code < 256; code++) begin
                dem = 8'(code);
                vld = (pass == 0);
                sum = 0; ones = 0; expm = '0;
                for (int i = 0; i < NS; i++) begin
                    case (dem[2*i +: 2])
                        2'd1: begin sum += 1; expm[2*i +: 2] = (ones == 0) ? 2'b01 : 2'b10; ones++; end
                        2'd2: begin sum += 2; expm[2*i +: 2] = 2'b11; end
                        2'd3: sum += 3;
                        default: ;
                    endcase
                end
                ok = (sum <= 2);
                tag = vld ? req_tag(dem, sum) : "R4";
                #1;
                check(vld ? (ok ? "R2" : "R3") : "R4", {31'd0, grant}, {31'd0, vld & ok});
                check(vld ? (ok ? "R2" : "R3") : "R4", {31'd0, stall}, {31'd0, vld & ~ok});
                @(negedge clk);
                if (vld && ok) check(tag, 32'(masks), 32'(expm));
                else check(vld ? "R10" : "R4", 32'(masks), 0);
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog act=timeout exp=done");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule